// File: doc/BRIEF.md
# I2C Master Byte Engine with Quarter-Bit Timing

This block is the bus-facing half of a small I2C sequencer. A controller hands it one command at a time: arm a master acknowledge, write a byte, write a byte behind a repeated START, read a byte, or close the transfer with STOP. The engine turns each command into SCL and open-drain SDA activity, reports the slave's acknowledge level after every written byte, and returns each received byte together with a completion pulse.

Bus timing comes from a run-time quarter length: every SCL bit is split into four quarters of `quarter_len` clocks each. The bus is claimed by the first write and stays claimed, with SCL parked low, until a STOP command. SDA is modelled as an output enable (drive low) plus a separate input, so the pad and pull-up stay outside the block.

Top module: `qi2c_engine`

## Requirements
- R1: After reset, scl is 1, sda_oe is 0, busy is 0, done is 0, nack is 0 and rd_data is 0.
- R2: Each quarter lasts quarter_len clocks (values 0 and 1 both mean one clock); SCL is high for the two middle quarters of a bit, so every SCL high pulse of a data bit lasts 2*quarter_len clocks.
- R3: Command code 1 (write) on a free bus produces a START (SDA falls while SCL is high) followed by the data byte MSB first and a ninth clock for the slave's acknowledge.
- R4: After every written byte, nack holds the SDA level seen on the ninth clock (1 means not acknowledged, 0 means acknowledged) until the next written byte.
- R5: After any byte the bus stays claimed: SCL remains low and no STOP appears until a STOP command is given.
- R6: A write on a claimed bus sends no START; command code 2 (write with restart) on a claimed bus releases SDA, raises SCL and produces a repeated START before the byte.
- R7: Command code 3 (read) on a claimed bus releases SDA for eight clocks, samples the bits MSB first and presents the byte on rd_data in the cycle done is high.
- R8: Command code 0 arms the master acknowledge without raising busy or done; the next read drives SDA low on its ninth clock only when armed and leaves SDA released otherwise; that read clears the arm.
- R9: Command code 4 on a claimed bus drives SDA low while SCL is low, then releases SCL, then releases SDA exactly one quarter later, leaving SCL high, SDA released and busy low.
- R10: SDA never changes while SCL is high except as a START or STOP condition.
- R11: busy is high from the cycle after a command is accepted until its byte or STOP completes; done is a one-cycle pulse in the cycle busy falls; commands presented while busy are ignored.
- R12: A read or STOP command on a free bus causes no bus activity and no busy, gives a done pulse in the following cycle and leaves rd_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quarter_len | input | QW | Clocks per quarter bit, held stable while busy |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_op | input | 3 | Command code: 0 arm ACK, 1 write, 2 write with restart, 3 read, 4 STOP |
| cmd_wdata | input | DW | Byte to send for codes 1 and 2 |
| busy | output | 1 | Command in progress on the bus |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Last byte received |
| nack | output | 1 | Acknowledge level of last written byte |
| scl | output | 1 | Bus clock |
| sda_oe | output | 1 | High pulls SDA low |
| sda_in | input | 1 | Level sensed on SDA |

## Verification
The hardest state to reach from the ports is the read that follows a repeated START with the master acknowledge armed, because it needs a claimed bus, a restart, an arm command and a slave that switches from acknowledging to sending data at the right clock edge. The bench gets there with a behavioural slave that watches SCL falls, drives SDA only while SCL is low, and is told per command whether it should acknowledge or transmit. The same monitor timestamps SCL and SDA edges so the STOP spacing and the high time at several quarter lengths are measured directly.

// File: rtl/qi2c_pkg.sv
package qi2c_pkg;
   localparam logic [2:0] OP_ARM     = 3'd0;
   localparam logic [2:0] OP_WRITE   = 3'd1;
   localparam logic [2:0] OP_RESTART = 3'd2;
   localparam logic [2:0] OP_READ    = 3'd3;
   localparam logic [2:0] OP_STOP    = 3'd4;

   typedef enum logic [2:0] {
      S_FREE  = 3'd0,
      S_HELD  = 3'd1,
      S_START = 3'd2,
      S_BIT   = 3'd3,
      S_STOP  = 3'd4
   } eng_state_e;
endpackage

// File: rtl/qi2c_qtr_timer.sv
module qi2c_qtr_timer #(
   parameter int QW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [QW-1:0] qlen,
   output logic          tick
);
   logic [QW-1:0] cnt;
   logic          last;

   assign last = (qlen <= QW'(1)) || (cnt == qlen - QW'(1));
   assign tick = run && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || last)
         cnt <= '0;
      else
         cnt <= cnt + QW'(1);
   end

   a_r2_idle_counter_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));
endmodule

// File: rtl/qi2c_seq.sv
module qi2c_seq
   import qi2c_pkg::*;
#(
   parameter int DW = 8,
   parameter int BW = $clog2(DW + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       cmd_valid,
   input  logic [2:0] cmd_op,
   input  logic       tx_msb,
   input  logic       mack_armed,
   output logic       run,
   output logic       scl,
   output logic       sda_oe,
   output logic       load,
   output logic       arm_set,
   output logic       samp_now,
   output logic       ack_now,
   output logic       shift_now,
   output logic       byte_fin,
   output logic       rd_mode,
   output logic       done
);
   eng_state_e    st;
   logic [1:0]    qph;
   logic [BW-1:0] bitn;
   logic          rd_q;
   logic          free, held, acc, last_bit, in_bit;

   assign free     = (st == S_FREE);
   assign held     = (st == S_HELD);
   assign in_bit   = (st == S_BIT);
   assign acc      = cmd_valid && (free || held) && (cmd_op <= OP_STOP);
   assign run      = (st == S_START) || in_bit || (st == S_STOP);
   assign last_bit = (bitn == BW'(DW));

   assign load      = acc && ((cmd_op == OP_WRITE) || (cmd_op == OP_RESTART));
   assign arm_set   = acc && (cmd_op == OP_ARM);
   assign samp_now  = tick && in_bit && (qph == 2'd1);
   assign ack_now   = samp_now && last_bit && !rd_q;
   assign shift_now = tick && in_bit && (qph == 2'd3) && !last_bit;
   assign byte_fin  = tick && in_bit && (qph == 2'd3) && last_bit;
   assign rd_mode   = rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= S_FREE;
         qph  <= 2'd0;
         bitn <= '0;
         rd_q <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            S_FREE, S_HELD: begin
               if (acc) begin
                  case (cmd_op)
                     OP_WRITE: begin
                        rd_q <= 1'b0;
                        bitn <= '0;
                        if (free) begin
                           st  <= S_START;
                           qph <= 2'd2;
                        end else begin
                           st  <= S_BIT;
                           qph <= 2'd0;
                        end
                     end
                     OP_RESTART: begin
                        rd_q <= 1'b0;
                        bitn <= '0;
                        st   <= S_START;
                        qph  <= free ? 2'd2 : 2'd0;
                     end
                     OP_READ: begin
                        if (free)
                           done <= 1'b1;
                        else begin
                           rd_q <= 1'b1;
                           bitn <= '0;
                           st   <= S_BIT;
                           qph  <= 2'd0;
                        end
                     end
                     OP_STOP: begin
                        if (free)
                           done <= 1'b1;
                        else begin
                           st  <= S_STOP;
                           qph <= 2'd0;
                        end
                     end
                     default: ;
                  endcase
               end
            end
            S_START: begin
               if (tick) begin
                  if (qph == 2'd3) begin
                     st  <= S_BIT;
                     qph <= 2'd0;
                  end else
                     qph <= qph + 2'd1;
               end
            end
            S_BIT: begin
               if (tick) begin
                  qph <= qph + 2'd1;
                  if (qph == 2'd3) begin
                     if (last_bit) begin
                        st   <= S_HELD;
                        done <= 1'b1;
                     end else
                        bitn <= bitn + BW'(1);
                  end
               end
            end
            S_STOP: begin
               if (tick) begin
                  if (qph == 2'd2) begin
                     st   <= S_FREE;
                     qph  <= 2'd0;
                     done <= 1'b1;
                  end else
                     qph <= qph + 2'd1;
               end
            end
            default: st <= S_FREE;
         endcase
      end
   end

   always_comb begin
      scl    = 1'b1;
      sda_oe = 1'b0;
      case (st)
         S_HELD: begin
            scl    = 1'b0;
            sda_oe = 1'b0;
         end
         S_START: begin
            scl    = (qph == 2'd1) || (qph == 2'd2);
            sda_oe = qph[1];
         end
         S_BIT: begin
            scl    = (qph == 2'd1) || (qph == 2'd2);
            sda_oe = last_bit ? (rd_q && mack_armed) : (!rd_q && !tx_msb);
         end
         S_STOP: begin
            scl    = (qph != 2'd0);
            sda_oe = (qph != 2'd2);
         end
         default: begin
            scl    = 1'b1;
            sda_oe = 1'b0;
         end
      endcase
   end

   a_r1_free_lines_released: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_FREE) |-> (scl && !sda_oe));

   a_r10_sda_quiet_while_high: assert property (@(posedge clk) disable iff (!rst_n)
      (in_bit && scl && $past(scl)) |-> (sda_oe == $past(sda_oe)));

   a_r11_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !run);

   a_r11_busy_end_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run) |-> done);

   a_r2_phase_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> (qph == $past(qph)));
endmodule

// File: rtl/qi2c_shift.sv
module qi2c_shift #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] load_data,
   input  logic          arm_set,
   input  logic          samp_now,
   input  logic          ack_now,
   input  logic          shift_now,
   input  logic          byte_fin,
   input  logic          rd_mode,
   input  logic          sda_s,
   output logic          tx_msb,
   output logic [DW-1:0] rd_data,
   output logic          nack,
   output logic          mack_armed
);
   logic [DW-1:0] shreg;
   logic          sbit;

   assign tx_msb = shreg[DW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg      <= '0;
         sbit       <= 1'b1;
         rd_data    <= '0;
         nack       <= 1'b0;
         mack_armed <= 1'b0;
      end else begin
         if (load)
            shreg <= load_data;
         else if (shift_now)
            shreg <= {shreg[DW-2:0], sbit};
         if (samp_now)
            sbit <= sda_s;
         if (ack_now)
            nack <= sda_s;
         if (arm_set)
            mack_armed <= 1'b1;
         else if (byte_fin && rd_mode)
            mack_armed <= 1'b0;
         if (byte_fin && rd_mode)
            rd_data <= shreg;
      end
   end

   a_r8_arm_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_fin && rd_mode) |=> !mack_armed);

   a_r4_nack_only_at_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_now |=> $stable(nack));

   a_r7_rdata_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      !(byte_fin && rd_mode) |=> $stable(rd_data));
endmodule

// File: rtl/qi2c_engine.sv
module qi2c_engine #(
   parameter int QW          = 6,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [QW-1:0] quarter_len,
   input  logic          cmd_valid,
   input  logic [2:0]    cmd_op,
   input  logic [DW-1:0] cmd_wdata,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] rd_data,
   output logic          nack,
   output logic          scl,
   output logic          sda_oe,
   input  logic          sda_in
);
   localparam int BW = $clog2(DW + 1);

   if (QW < 1 || QW > 16) begin : g_bad_qw
      $error("qi2c_engine: QW must lie in 1..16");
   end
   if (DW < 2) begin : g_bad_dw
      $error("qi2c_engine: DW must be at least 2");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("qi2c_engine: SYNC_STAGES must lie in 0..4");
   end

   logic sda_s, tick, load, arm_set, samp_now, ack_now, shift_now;
   logic byte_fin, rd_mode, tx_msb, mack_armed;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign sda_s = sda_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pipe <= '1;
         else begin
            pipe[0] <= sda_in;
            for (int i = 1; i < SYNC_STAGES; i++)
               pipe[i] <= pipe[i-1];
         end
      end
      assign sda_s = pipe[SYNC_STAGES-1];
   end

   qi2c_qtr_timer #(.QW(QW)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy),
      .qlen (quarter_len),
      .tick (tick)
   );

   qi2c_seq #(.DW(DW), .BW(BW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .tx_msb    (tx_msb),
      .mack_armed(mack_armed),
      .run       (busy),
      .scl       (scl),
      .sda_oe    (sda_oe),
      .load      (load),
      .arm_set   (arm_set),
      .samp_now  (samp_now),
      .ack_now   (ack_now),
      .shift_now (shift_now),
      .byte_fin  (byte_fin),
      .rd_mode   (rd_mode),
      .done      (done)
   );

   qi2c_shift #(.DW(DW)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_data (cmd_wdata),
      .arm_set   (arm_set),
      .samp_now  (samp_now),
      .ack_now   (ack_now),
      .shift_now (shift_now),
      .byte_fin  (byte_fin),
      .rd_mode   (rd_mode),
      .sda_s     (sda_s),
      .tx_msb    (tx_msb),
      .rd_data   (rd_data),
      .nack      (nack),
      .mack_armed(mack_armed)
   );

   a_r11_no_accept_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (busy || done));
endmodule

// File: tb/qi2c_engine_bench.sv
module qi2c_engine_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] quarter_len = 6'd3;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_op = 3'd0;
   logic [7:0] cmd_wdata = 8'd0;
   logic       busy, done, nack, scl, sda_oe;
   logic [7:0] rd_data;
   logic       slave_pull = 1'b0;
   logic       sda_line;

   assign sda_line = !(sda_oe || slave_pull);

   always #5 clk = ~clk;

   qi2c_engine u_qi2c_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .quarter_len(quarter_len),
      .cmd_valid  (cmd_valid),
      .cmd_op     (cmd_op),
      .cmd_wdata  (cmd_wdata),
      .busy       (busy),
      .done       (done),
      .rd_data    (rd_data),
      .nack       (nack),
      .scl        (scl),
      .sda_oe     (sda_oe),
      .sda_in     (sda_line)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // bus monitor and slave model
   int   cyc_n = 0, rise_cyc = 0, hi_cnt = 0, last_hi = 0, stop_gap = 0;
   int   start_cnt = 0, stop_cnt = 0, byte_cnt = 0, bitpos = 0;
   logic prev_scl = 1'b1, prev_sda = 1'b1;
   logic [7:0] rx_shift = 8'd0, rx_byte = 8'd0, tx_byte = 8'd0;
   logic ack_lvl = 1'b1;
   bit   slave_tx = 0, ack_en = 1;

   always @(negedge clk) begin
      cyc_n++;
      if (rst_n) begin
         if (prev_scl && scl) begin
            if (prev_sda && !sda_line) begin
               start_cnt++;
               bitpos = 0;
            end else if (!prev_sda && sda_line) begin
               stop_cnt++;
               bitpos = 0;
               stop_gap = cyc_n - rise_cyc;
            end
         end
         if (!prev_scl && scl) begin
            rise_cyc = cyc_n;
            hi_cnt = 1;
            if (bitpos < 8) begin
               rx_shift = {rx_shift[6:0], sda_line};
               bitpos++;
            end else begin
               ack_lvl = sda_line;
               rx_byte = rx_shift;
               byte_cnt++;
               bitpos = 0;
            end
         end else if (scl)
            hi_cnt++;
         if (prev_scl && !scl)
            last_hi = hi_cnt;
         if (!scl) begin
            if (bitpos < 8)
               slave_pull = slave_tx && !tx_byte[7-bitpos];
            else
               slave_pull = !slave_tx && ack_en;
         end
         prev_scl = scl;
         prev_sda = sda_line;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   bit busy_seen, got_done;

   task automatic wait_done();
      busy_seen = 0;
      got_done = 0;
      for (int i = 0; i < 5000; i++) begin
         if (done) begin
            got_done = 1;
            break;
         end
         if (busy) busy_seen = 1;
         @(negedge clk);
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic [7:0] d);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_wdata = d;
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_done();
   endtask

   task automatic t_reset();
      chk("R1 scl", scl, 1);
      chk("R1 sda_oe", sda_oe, 0);
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 nack", nack, 0);
      chk("R1 rd_data", rd_data, 0);
   endtask

   task automatic t_write_from_free();
      int s0, p0;
      s0 = start_cnt; p0 = stop_cnt;
      ack_en = 1; slave_tx = 0;
      issue(3'd1, 8'hA5);
      chk("R11 done seen", got_done, 1);
      chk("R11 busy seen", busy_seen, 1);
      chk("R3 start", start_cnt - s0, 1);
      chk("R3 byte", rx_byte, 8'hA5);
      chk("R4 ack", nack, 0);
      chk("R5 scl low", scl, 0);
      chk("R5 no stop", stop_cnt - p0, 0);
      chk("R2 high time", last_hi, 6);
      chk("R11 busy low at done", busy, 0);
   endtask

   task automatic t_write_claimed_nack();
      int s0;
      s0 = start_cnt;
      ack_en = 0;
      issue(3'd1, 8'h3C);
      chk("R6 no start", start_cnt - s0, 0);
      chk("R3 byte", rx_byte, 8'h3C);
      chk("R4 nack", nack, 1);
      chk("R10 no stop", stop_cnt, 0);
   endtask

   task automatic t_busy_ignore();
      int b0;
      b0 = byte_cnt;
      ack_en = 1;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd1; cmd_wdata = 8'h11;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (3) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd1; cmd_wdata = 8'hFF;
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_done();
      repeat (200) @(negedge clk);
      chk("R11 one byte", byte_cnt - b0, 1);
      chk("R11 byte kept", rx_byte, 8'h11);
      chk("R4 ack again", nack, 0);
      chk("R5 still held", scl, 0);
   endtask

   task automatic t_restart_and_reads();
      int s0;
      s0 = start_cnt;
      issue(3'd2, 8'h3D);
      chk("R6 repeated start", start_cnt - s0, 1);
      chk("R6 byte", rx_byte, 8'h3D);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd0;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R8 arm no busy", busy, 0);
      chk("R8 arm no done", done, 0);
      slave_tx = 1; tx_byte = 8'h96;
      issue(3'd3, 8'h00);
      chk("R7 read byte", rd_data, 8'h96);
      chk("R8 armed ack low", ack_lvl, 0);
      tx_byte = 8'h5A;
      issue(3'd3, 8'h00);
      chk("R7 read byte", rd_data, 8'h5A);
      chk("R8 unarmed ack released", ack_lvl, 1);
      chk("R4 nack untouched by read", nack, 0);
      slave_tx = 0;
   endtask

   task automatic t_stop(input int len);
      int p0, s0;
      p0 = stop_cnt; s0 = start_cnt;
      slave_tx = 0;
      issue(3'd4, 8'h00);
      @(negedge clk);
      chk("R9 one stop", stop_cnt - p0, 1);
      chk("R9 gap one quarter", stop_gap, len);
      chk("R9 scl high", scl, 1);
      chk("R9 sda released", sda_oe, 0);
      chk("R9 idle", busy, 0);
      chk("R10 no extra start", start_cnt - s0, 0);
   endtask

   task automatic t_free_ignored();
      int p0, s0;
      p0 = stop_cnt; s0 = start_cnt;
      issue(3'd4, 8'h00);
      chk("R12 stop done", got_done, 1);
      chk("R12 stop no busy", busy_seen, 0);
      issue(3'd3, 8'h00);
      chk("R12 read done", got_done, 1);
      chk("R12 read no busy", busy_seen, 0);
      repeat (20) @(negedge clk);
      chk("R12 rd_data kept", rd_data, 8'h5A);
      chk("R12 no bus events", (stop_cnt - p0) + (start_cnt - s0), 0);
      chk("R12 scl high", scl, 1);
   endtask

   task automatic t_rate(input logic [5:0] len, input logic [7:0] d, input int hi);
      quarter_len = len;
      ack_en = 1;
      issue(3'd1, d);
      chk("R2 high time", last_hi, hi);
      chk("R3 byte", rx_byte, d);
      chk("R4 ack", nack, 0);
      t_stop(hi / 2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_from_free();
      t_write_claimed_nack();
      t_busy_ignore();
      t_restart_and_reads();
      t_stop(3);
      t_free_ignored();
      t_rate(6'd5, 8'h80, 10);
      t_rate(6'd0, 8'h01, 2);
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule